// File: doc/BRIEF.md
# Scalable System Timestamp Counter

This block keeps one free-running timestamp for a whole chip. A slow reference oscillator produces a single-cycle `ref_tick` pulse in the fast clock domain. On each pulse the count grows by a programmable step, not by one. A low-rate source can therefore present a much higher nominal counting rate. The count is published as a 64-bit value. When the counter is configured narrower than 64 bits, the unused upper bits read as zero. The count wraps silently when it reaches its maximum.

Software controls the block through a small word-addressed register port with a write-enable strobe and a combinational read path. Through this port it can start and stop counting, choose the step, and store the nominal rate in Hz so other software can read it. It can also load a new 64-bit count, written as two 32-bit halves: the low half is held in a side register, and both halves take effect when the high half is written. A debug-halt input stops the count, but only while halt-on-debug is enabled.

Top module: `tstamp_counter`

## Requirements
- R1: After reset the count is 0. The control register reads 0, the step register reads 1 and the rate register reads 0.
- R2: When counting is enabled (control bit 0 = 1), the block is not halted, and `ref_tick` is high, the count one cycle later equals the old count plus the step register value.
- R3: When control bit 0 is 0, the count holds even when `ref_tick` pulses.
- R4: In a cycle with `ref_tick` low and no count load, the count holds.
- R5: When control bit 1 (halt-on-debug) is 1 and `dbg_halt` is high, ticks are ignored and the count holds. When control bit 1 is 0, `dbg_halt` has no effect.
- R6: A step register value of 0 advances the count by 1 per tick. The register still reads back 0.
- R7: A write to offset 0x08 only stages the low half. The count does not take that value until offset 0x0C is written.
- R8: A write to offset 0x0C loads `{wdata, staged low}` into the count in the next cycle. This load wins over a tick in the same cycle.
- R9: The count wraps modulo 2^CNT_W with no flag. Bits of `count_o` at or above CNT_W are always 0.
- R10: The rate register at offset 0x10 reads back as written and has no effect on counting.
- R11: Reads: 0x00 returns {30'b0, halt-on-debug, enable}. 0x04 returns the step register. 0x08 returns live count bits [31:0], 0x0C returns live count bits [63:32], and 0x10 returns the rate register. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse from the slow reference |
| dbg_halt | input | 1 | Debug halt request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read byte offset |
| rd_data | output | 32 | Register read data (combinational) |
| count_o | output | 64 | Current timestamp |

## Verification
A corrupted step register or enable/halt decode shows on `count_o` one cycle after the next reference tick, as a wrong increment or as a missing or extra advance. A wrong staged low half stays hidden until a high-half write, and it shows in the cycle after that write as a wrong low word of `count_o`. A broken load priority shows in that same cycle as a loaded value off by one step. Errors in the read mux show immediately on `rd_data` for the offset being read.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_STEP = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_CLO  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CHI  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_RATE = 5'h10;

    typedef struct packed {
        logic halt_en;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/tsc_regs.sv
module tsc_regs
    import tsc_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic [STEP_W-1:0] step,
    output logic [DATA_W-1:0] rate,
    output logic              load,
    output logic [CNT_W-1:0]  load_val
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [STEP_W-1:0] step;
        logic [DATA_W-1:0] rate;
        logic [DATA_W-1:0] stage;
    } regs_t;

    localparam regs_t RST_VAL = '{ctrl: '0, step: STEP_W'(1), rate: '0, stage: '0};

    regs_t r_d, r_q;
    logic [2*DATA_W-1:0] full_w;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_addr)
                OFS_CTRL: begin
                    r_d.ctrl.run     = wr_data[0];
                    r_d.ctrl.halt_en = wr_data[1];
                end
                OFS_STEP: r_d.step  = wr_data[STEP_W-1:0];
                OFS_CLO:  r_d.stage = wr_data;
                OFS_RATE: r_d.rate  = wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= RST_VAL;
        else        r_q <= r_d;
    end

    assign full_w   = {wr_data, r_q.stage};
    assign load     = wr_en && (wr_addr == OFS_CHI);
    assign load_val = full_w[CNT_W-1:0];
    assign ctrl     = r_q.ctrl;
    assign step     = r_q.step;
    assign rate     = r_q.rate;
endmodule

// File: rtl/tsc_count.sv
module tsc_count
    import tsc_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              dbg_halt,
    input  ctrl_t             ctrl,
    input  logic [STEP_W-1:0] step,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  count
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t c_d, c_q;
    logic [CNT_W-1:0] inc_w;
    logic             frozen_w;
    logic             adv_w;

    always_comb begin
        inc_w    = (step == '0) ? CNT_W'(1) : CNT_W'(step);
        frozen_w = ctrl.halt_en && dbg_halt;
        adv_w    = ctrl.run && ref_tick && !frozen_w;
        c_d      = c_q;
        if (load)       c_d.cnt = load_val;
        else if (adv_w) c_d.cnt = c_q.cnt + inc_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count = c_q.cnt;
endmodule

// File: rtl/tsc_rdmux.sv
module tsc_rdmux
    import tsc_pkg::*;
#(
    parameter int STEP_W = 16
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  ctrl_t             ctrl,
    input  logic [STEP_W-1:0] step,
    input  logic [DATA_W-1:0] rate,
    input  logic [63:0]       count64,
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        case (rd_addr)
            OFS_CTRL: rd_data = {30'b0, ctrl.halt_en, ctrl.run};
            OFS_STEP: rd_data = DATA_W'(step);
            OFS_CLO:  rd_data = count64[31:0];
            OFS_CHI:  rd_data = count64[63:32];
            OFS_RATE: rd_data = rate;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tstamp_counter.sv
module tstamp_counter
    import tsc_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int STEP_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_tick,
    input  logic        dbg_halt,
    input  logic        wr_en,
    input  logic [4:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [4:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic [63:0] count_o
);
    ctrl_t             ctrl_w;
    logic [STEP_W-1:0] step_w;
    logic [31:0]       rate_w;
    logic              load_w;
    logic [CNT_W-1:0]  load_val_w;
    logic [CNT_W-1:0]  cnt_w;
    logic              run_w;
    logic              halt_en_w;

    tsc_regs #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctrl(ctrl_w), .step(step_w), .rate(rate_w), .load(load_w), .load_val(load_val_w)
    );

    tsc_count #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_count (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .dbg_halt(dbg_halt),
        .ctrl(ctrl_w), .step(step_w), .load(load_w), .load_val(load_val_w), .count(cnt_w)
    );

    assign count_o   = 64'(cnt_w);
    assign run_w     = ctrl_w.run;
    assign halt_en_w = ctrl_w.halt_en;

    tsc_rdmux #(.STEP_W(STEP_W)) u_rdmux (
        .rd_addr(rd_addr), .ctrl(ctrl_w), .step(step_w), .rate(rate_w),
        .count64(count_o), .rd_data(rd_data)
    );
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
    parameter int CNT_W  = 64,
    parameter int STEP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_tick,
    input logic              dbg_halt,
    input logic              wr_en,
    input logic [4:0]        wr_addr,
    input logic [63:0]       count_o,
    input logic              run,
    input logic              halt_en,
    input logic [STEP_W-1:0] step,
    input logic              load,
    input logic [CNT_W-1:0]  load_val
);
    localparam logic [63:0] MASK = (64'd1 << CNT_W) - 64'd1;

    logic [63:0] eff_w;
    logic        hold_w;
    assign eff_w  = (step == '0) ? 64'd1 : 64'(step);
    assign hold_w = (!run || (halt_en && dbg_halt) || !ref_tick) && !load;

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ref_tick && !(halt_en && dbg_halt) && !load)
        |=> count_o == (($past(count_o) + $past(eff_w)) & MASK));

    p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(count_o));

    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_tick && !load) |=> $stable(count_o));

    p_halt_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_en && dbg_halt && !load) |=> $stable(count_o));

    p_lo_staged_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 5'h08 && hold_w) |=> $stable(count_o));

    p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count_o == 64'($past(load_val)));

    p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o & ~MASK) == 64'd0);
endmodule

bind tstamp_counter tsc_checker #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .dbg_halt(dbg_halt),
    .wr_en(wr_en), .wr_addr(wr_addr), .count_o(count_o),
    .run(run_w), .halt_en(halt_en_w), .step(step_w),
    .load(load_w), .load_val(load_val_w)
);

// File: tb/sim_tstamp_counter.sv
`timescale 1ns/1ps
module sim_tstamp_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        dbg_halt = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [63:0] count_o;

    always #5 clk = ~clk;

    tstamp_counter u0 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .dbg_halt(dbg_halt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .count_o(count_o)
    );

    typedef struct {
        bit          is_rd;
        int          req;
        logic [63:0] exp;
    } item_t;

    item_t       sb_q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;

    logic [63:0] m_cnt = '0;
    logic [31:0] m_stage = '0;
    logic        m_run = 0, m_halt_en = 0;
    logic [15:0] m_step = 16'd1;

    task automatic push_cnt(int req);
        item_t it;
        it.is_rd = 0; it.req = req; it.exp = m_cnt;
        sb_q.push_back(it);
    endtask

    // one cycle of stimulus; model updated from the requirements
    task automatic cyc(bit tick, bit halt, bit wen, logic [4:0] a, logic [31:0] d, int req);
        @(negedge clk);
        ref_tick = tick; dbg_halt = halt; wr_en = wen; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        if (wen && a == 5'h0C)
            m_cnt = {d, m_stage};
        else if (m_run && tick && !(m_halt_en && halt))
            m_cnt = m_cnt + ((m_step == 0) ? 64'd1 : 64'(m_step));
        if (wen) begin
            case (a)
                5'h00: begin m_run = d[0]; m_halt_en = d[1]; end
                5'h04: m_step = d[15:0];
                5'h08: m_stage = d;
                default: ;
            endcase
        end
        ref_tick = 0; dbg_halt = 0; wr_en = 0;
        push_cnt(req);
    endtask

    task automatic rd(logic [4:0] a, logic [31:0] e, int req);
        item_t it;
        @(posedge clk);
        #1;
        rd_addr = a;
        it.is_rd = 1; it.req = req; it.exp = 64'(e);
        sb_q.push_back(it);
    endtask

    // monitor
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [63:0] act;
            it = sb_q.pop_front();
            act = it.is_rd ? 64'(rd_data) : count_o;
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL R%0d %s actual=%h expected=%h", it.req,
                         it.is_rd ? "rd_data" : "count_o", act, it.exp);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        push_cnt(1);
        rd(5'h00, 32'd0, 1);
        rd(5'h04, 32'd1, 1);
        rd(5'h10, 32'd0, 1);
        // R2 step 1 then step 5
        cyc(0, 0, 1, 5'h00, 32'd1, 2);
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, 2);
        cyc(0, 0, 1, 5'h04, 32'd5, 2);
        cyc(1, 0, 0, 0, 0, 2);
        cyc(1, 0, 0, 0, 0, 2);
        // R4 no tick
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 4);
        // R3 disabled
        cyc(0, 0, 1, 5'h00, 32'd0, 3);
        cyc(1, 0, 0, 0, 0, 3);
        cyc(1, 0, 0, 0, 0, 3);
        // R5 halt-on-debug enabled
        cyc(0, 0, 1, 5'h00, 32'd3, 5);
        cyc(1, 1, 0, 0, 0, 5);
        cyc(0, 1, 0, 0, 0, 5);
        cyc(1, 0, 0, 0, 0, 5);
        // R5 halt ignored when disabled
        cyc(0, 0, 1, 5'h00, 32'd1, 5);
        cyc(1, 1, 0, 0, 0, 5);
        // R6 zero step
        cyc(0, 0, 1, 5'h04, 32'd0, 6);
        cyc(1, 0, 0, 0, 0, 6);
        cyc(1, 0, 0, 0, 0, 6);
        rd(5'h04, 32'd0, 6);
        // R7 staged low half does not disturb count
        cyc(1, 0, 1, 5'h08, 32'hFFFF_FFF0, 7);
        cyc(0, 0, 0, 0, 0, 7);
        // R8 high write loads and wins over tick
        cyc(1, 0, 1, 5'h0C, 32'hFFFF_FFFF, 8);
        rd(5'h08, 32'hFFFF_FFF0, 11);
        rd(5'h0C, 32'hFFFF_FFFF, 11);
        // R9 wrap
        cyc(0, 0, 1, 5'h04, 32'h20, 9);
        cyc(1, 0, 0, 0, 0, 9);
        rd(5'h0C, 32'd0, 9);
        rd(5'h08, 32'h10, 9);
        // R10 rate register
        cyc(0, 0, 1, 5'h10, 32'h0ABC_DEF0, 10);
        rd(5'h10, 32'h0ABC_DEF0, 10);
        cyc(1, 0, 0, 0, 0, 10);
        // R11 other reads
        rd(5'h00, 32'd1, 11);
        rd(5'h14, 32'd0, 11);
        rd(5'h1C, 32'd0, 11);
        // R8 load with counter disabled
        cyc(0, 0, 1, 5'h00, 32'd0, 8);
        cyc(0, 0, 1, 5'h08, 32'h1234_5678, 8);
        cyc(0, 0, 1, 5'h0C, 32'h0000_00AB, 8);
        repeat (2) @(posedge clk);
        done = 1;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
        end
    end

    initial begin
        wait (done || n_fail < 0);
        @(negedge clk); @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100001) @(posedge clk);
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule